// File: doc/BRIEF.md
# Hashed page table entry allocator

This block installs one new address translation into a hashed page table held in ordinary memory. The caller supplies the effective address, the segment identifier and four attribute bits, and the base addresses of the two candidate groups (primary and secondary hash), each holding eight two-word entries. The engine walks the entries over a word-wide memory port. It then writes the new entry, upper word first, into the slot it picked.

In insert mode the engine takes the first slot whose valid bit is clear. It scans the primary group first and then the secondary group. An entry placed in the secondary group carries the secondary-hash flag. In replace mode every slot is taken to be occupied, and the engine looks for a victim whose changed bit is clear. If all sixteen candidates are changed, it overwrites the last one it read. The hash itself and any write-back of the evicted page to backing store belong to the caller.

Top module: `pte_alloc_engine`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o and mem_we_o are all low.
- R2: In insert mode (replace_i=0) the engine reads the upper word at group base + 8*k for k = 0..7 in ascending order. A slot is free when upper-word bit 31 is 0, and the first free slot wins. A win in the primary group reports status_o=2 and sec_o=0.
- R3: If no primary slot is free, the secondary group is scanned in the same order. A win there reports sec_o=1, and the written upper word has bit 6 (secondary-hash flag) set.
- R4: If neither group has a free slot in insert mode, status_o=1, sec_o=1, slot_o is secondary base + 56, and no memory write is issued.
- R5: The upper word written is: bit 31 = 1 (valid), bits 30:7 = vsid_i, bit 6 = secondary-hash flag, bits 5:0 = ea_i[27:22].
- R6: The lower word written is: bits 31:12 = ea_i[31:12], bits 11:9 = 0, bit 8 = 1 (referenced), bit 7 = 1 (changed), bits 6:3 = attr_i, bit 2 = 0, bits 1:0 = 2'b10 (protection).
- R7: A write stores the upper word at the slot address and then, in the next cycle, the lower word at slot address + 4.
- R8: In replace mode (replace_i=1) the engine reads the lower word at slot address + 4 and picks the first entry whose bit 7 (changed) is 0. It searches the primary group, then the secondary group. The valid bit is not examined. A hit reports status_o=2 and writes the new entry there.
- R9: In replace mode, if all 16 entries have bit 7 set, the engine reports status_o=1 and overwrites secondary slot 7 with the new entry, with the secondary-hash flag set.
- R10: The engine issues at most one memory request per cycle. Each read is followed by exactly one decision cycle. busy_o stays high from the cycle after start_i is accepted until done_o. done_o is a single-cycle pulse during which busy_o is low. A start_i seen while busy is ignored.
- R11: At done_o, slot_o holds the address of the last entry examined and sec_o tells which group that entry belongs to. Both hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| replace_i | input | 1 | 0 = insert into a free slot, 1 = replace an unmodified entry |
| ea_i | input | 32 | Effective address of the page |
| vsid_i | input | 24 | Segment identifier for the upper word |
| attr_i | input | 4 | Page attribute bits for the lower word |
| pri_base_i | input | AW | Primary group base address (64-byte aligned) |
| sec_base_i | input | AW | Secondary group base address (64-byte aligned) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 2 = slot chosen, 1 = candidates exhausted |
| slot_o | output | AW | Address of the last entry examined |
| sec_o | output | 1 | Last entry examined lies in the secondary group |
| mem_req_o | output | 1 | Memory request strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid one cycle after a read request |

## Verification
Count the edge that accepts start_i as edge zero. An operation that examines n entries raises done_o after edge 2n when it writes nothing, and after edge 2n+2 when it writes. The extra two cycles are the upper-word and lower-word writes. The scoreboard stores this latency with the expected status, slot address and group for each operation. The monitor samples on falling edges, when done_o is high. At that point it also compares the whole memory image against a model updated by the driver from the requirements. On the following falling edge it confirms that done_o has dropped.

// File: rtl/pte_alloc_pkg.sv
package pte_alloc_pkg;
  localparam int unsigned VSID_W = 24;
  localparam int unsigned ATTR_W = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CHK, S_WHI, S_WLO, S_DONE
  } eng_state_e;

  localparam logic [1:0] STAT_HIT = 2'd2;
  localparam logic [1:0] STAT_EXH = 2'd1;

  typedef struct packed {
    logic [31:0] hi;
    logic [31:0] lo;
  } pte_t;
endpackage

// File: rtl/pte_entry_build.sv
module pte_entry_build
  import pte_alloc_pkg::*;
(
  input  logic [31:0]       ea_i,
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic              sec_i,
  output pte_t              pte_o
);
  always_comb begin
    pte_o.hi = {1'b1, vsid_i, sec_i, ea_i[27:22]};
    // referenced + changed set, protection 2'b10
    pte_o.lo = {ea_i[31:12], 3'b000, 1'b1, 1'b1, attr_i, 1'b0, 2'b10};
  end
endmodule

// File: rtl/pte_scan_ctr.sv
module pte_scan_ctr #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned ENTRY_BYTES = 8,
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [AW-1:0] pri_base_i,
  input  logic [AW-1:0] sec_base_i,
  output logic          sec_o,
  output logic          last_o,
  output logic [AW-1:0] slot_addr_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned OFF_W  = $clog2(ENTRY_BYTES);

  logic [SLOT_W-1:0] slot_q;
  logic              sec_q;
  logic              slot_end;

  assign slot_end = (slot_q == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      sec_q  <= 1'b0;
    end else if (clear_i) begin
      slot_q <= '0;
      sec_q  <= 1'b0;
    end else if (step_i) begin
      if (!slot_end) begin
        slot_q <= slot_q + 1'b1;
      end else if (!sec_q) begin
        slot_q <= '0;
        sec_q  <= 1'b1;
      end
    end
  end

  assign sec_o       = sec_q;
  assign last_o      = slot_end && sec_q;
  assign slot_addr_o = (sec_q ? sec_base_i : pri_base_i)
                     + (AW'(slot_q) << OFF_W);

  // secondary group entered only after the last primary slot was stepped
  assert_sec_after_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_q) |-> ($past(slot_end) && $past(step_i)));
endmodule

// File: rtl/pte_alloc_engine.sv
module pte_alloc_engine
  import pte_alloc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned SLOTS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              replace_i,
  input  logic [31:0]       ea_i,
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [AW-1:0]     pri_base_i,
  input  logic [AW-1:0]     sec_base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [AW-1:0]     slot_o,
  output logic              sec_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);
  localparam int unsigned ENTRY_BYTES = 8;
  localparam logic [AW-1:0] LO_OFF = AW'(ENTRY_BYTES / 2);

  eng_state_e state_q, state_d;
  logic              mode_q;
  logic [31:0]       ea_q;
  logic [VSID_W-1:0] vsid_q;
  logic [ATTR_W-1:0] attr_q;
  logic [AW-1:0]     pri_q, sec_q;
  logic [1:0]        status_q, status_d;

  logic          accept, clear, step, hit;
  logic          scan_sec, scan_last;
  logic [AW-1:0] slot_addr;
  pte_t          pte;

  assign accept = (state_q == S_IDLE) && start_i;
  assign clear  = accept;

  pte_scan_ctr #(.SLOTS(SLOTS), .ENTRY_BYTES(ENTRY_BYTES), .AW(AW)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .step_i     (step),
    .pri_base_i (pri_q),
    .sec_base_i (sec_q),
    .sec_o      (scan_sec),
    .last_o     (scan_last),
    .slot_addr_o(slot_addr)
  );

  pte_entry_build u_build (
    .ea_i  (ea_q),
    .vsid_i(vsid_q),
    .attr_i(attr_q),
    .sec_i (scan_sec),
    .pte_o (pte)
  );

  // replace: changed bit clear; insert: valid bit clear
  assign hit = mode_q ? !mem_rdata_i[7] : !mem_rdata_i[31];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      mode_q   <= 1'b0;
      ea_q     <= '0;
      vsid_q   <= '0;
      attr_q   <= '0;
      pri_q    <= '0;
      sec_q    <= '0;
      status_q <= '0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      if (accept) begin
        mode_q <= replace_i;
        ea_q   <= ea_i;
        vsid_q <= vsid_i;
        attr_q <= attr_i;
        pri_q  <= pri_base_i;
        sec_q  <= sec_base_i;
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    step     = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d  = S_RD;
        status_d = '0;
      end
      S_RD:   state_d = S_CHK;
      S_CHK: begin
        if (hit) begin
          status_d = STAT_HIT;
          state_d  = S_WHI;
        end else if (!scan_last) begin
          step    = 1'b1;
          state_d = S_RD;
        end else begin
          status_d = STAT_EXH;
          state_d  = mode_q ? S_WHI : S_DONE;
        end
      end
      S_WHI:  state_d = S_WLO;
      S_WLO:  state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = slot_addr;
    mem_wdata_o = pte.hi;
    unique case (state_q)
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = mode_q ? slot_addr + LO_OFF : slot_addr;
      end
      S_WHI: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      S_WLO: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = slot_addr + LO_OFF;
        mem_wdata_o = pte.lo;
      end
      default: ;
    endcase
  end

  assign busy_o   = (state_q == S_RD) || (state_q == S_CHK) ||
                    (state_q == S_WHI) || (state_q == S_WLO);
  assign done_o   = (state_q == S_DONE);
  assign status_o = status_q;
  assign slot_o   = slot_addr;
  assign sec_o    = scan_sec;

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!mem_req_o && !done_o));

  assert_hi_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_addr_o[2]) |-> (mem_wdata_o[31] && mem_wdata_o[6] == sec_o
                                      && mem_wdata_o[30:7] == vsid_q));

  assert_lo_word_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o[2]) |-> (mem_wdata_o[8:7] == 2'b11 && mem_wdata_o[1:0] == 2'b10
                                     && mem_wdata_o[31:12] == ea_q[31:12]));

  assert_write_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_addr_o[2]) |=>
      (mem_req_o && mem_we_o && mem_addr_o[2] && mem_addr_o[AW-1:3] == $past(mem_addr_o[AW-1:3])));

  assert_no_write_on_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHK && !hit && scan_last && !mode_q) |=> !mem_req_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_status_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o == STAT_HIT || status_o == STAT_EXH));
endmodule

// File: tb/pte_alloc_engine_tb.sv
module pte_alloc_engine_tb;
  localparam logic [31:0] PRI = 32'h0000_1000;
  localparam logic [31:0] SEC = 32'h0000_1040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start, repl;
  logic [31:0] ea;
  logic [23:0] vsid;
  logic [3:0]  attr;
  logic        busy, done, sec;
  logic [1:0]  status;
  logic [31:0] slot;
  logic        req, we;
  logic [31:0] addr, wdata, rdata;

  pte_alloc_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .replace_i(repl),
    .ea_i(ea), .vsid_i(vsid), .attr_i(attr),
    .pri_base_i(PRI), .sec_base_i(SEC),
    .busy_o(busy), .done_o(done), .status_o(status), .slot_o(slot), .sec_o(sec),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata)
  );

  logic [31:0] mem [32];
  logic [31:0] exp_mem [32];

  always @(posedge clk) begin
    if (req && we) mem[addr[6:2]] <= wdata;
    if (req && !we) rdata <= mem[addr[6:2]];
  end

  typedef struct {
    logic [1:0]  st;
    logic [31:0] slot;
    logic        sec;
    int          lat;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int tests = 0, fails = 0, seen = 0, cyc = 0, st_cyc = 0;
  logic prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (prev_done) chk(!done, "R10 done single pulse", 64'(done), 64'd0);
    if (done && sb.size() > 0) begin
      exp_t e;
      bit mem_ok;
      e = sb.pop_front();
      chk(status == e.st, {e.tag, " status"}, 64'(status), 64'(e.st));
      chk(slot == e.slot, {e.tag, " slot R11"}, 64'(slot), 64'(e.slot));
      chk(sec == e.sec, {e.tag, " group R11"}, 64'(sec), 64'(e.sec));
      chk((cyc - st_cyc) == e.lat && !busy, {e.tag, " latency R10"}, 64'(cyc - st_cyc), 64'(e.lat));
      mem_ok = 1'b1;
      for (int i = 0; i < 32; i++) if (mem[i] !== exp_mem[i]) mem_ok = 1'b0;
      chk(mem_ok, {e.tag, " memory image R5 R6 R7"}, 64'd0, 64'd1);
      seen++;
    end
    prev_done = done;
  end

  task automatic poke(input int idx, input logic [31:0] v);
    mem[idx] = v;
    exp_mem[idx] = v;
  endtask

  task automatic wipe();
    for (int i = 0; i < 32; i++) poke(i, 32'h0);
  endtask

  // driver: predicts from requirements, pushes, then starts the engine
  task automatic run(input string tag, input bit m, input logic [31:0] a,
                     input logic [23:0] v, input logic [3:0] at, input bit poke_busy);
    exp_t e;
    bit found = 0;
    int fg = 1, fk = 7, n = 0, target;
    for (int g = 0; g < 2; g++)
      for (int k = 0; k < 8; k++)
        if (!found) begin
          logic [31:0] w;
          n++;
          w = m ? mem[g*16 + 2*k + 1] : mem[g*16 + 2*k];
          if (m ? !w[7] : !w[31]) begin
            found = 1; fg = g; fk = k;
          end
        end
    e.st   = found ? 2'd2 : 2'd1;
    e.sec  = fg[0];
    e.slot = (fg == 1 ? SEC : PRI) + 32'(fk * 8);
    e.lat  = (found || m) ? 2*n + 2 : 2*n;
    e.tag  = tag;
    if (found || m) begin
      exp_mem[fg*16 + 2*fk]     = {1'b1, v, fg[0], a[27:22]};
      exp_mem[fg*16 + 2*fk + 1] = {a[31:12], 3'b000, 2'b11, at, 1'b0, 2'b10};
    end
    sb.push_back(e);
    target = seen + 1;
    @(negedge clk);
    start = 1'b1; repl = m; ea = a; vsid = v; attr = at;
    st_cyc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, {tag, " busy after start R10"}, 64'(busy), 64'd1);
    if (poke_busy) begin
      @(negedge clk);
      start = 1'b1; repl = ~m; ea = ~a; vsid = ~v; attr = ~at;
      @(negedge clk);
      start = 1'b0;
    end
    while (seen != target) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    start = 0; repl = 0; ea = 0; vsid = 0; attr = 0;
    wipe();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req && !we, "R1 reset outputs", {busy, done, req, we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !req, "R1 idle after reset", {busy, done, req}, 0);

    // R2: empty table -> primary slot 0, then slot 1
    run("R2 empty primary", 0, 32'hABCD_E123, 24'h12_3456, 4'h5, 0);
    run("R2 next free slot", 0, 32'h1234_5000, 24'h65_4321, 4'hA, 0);

    // R2: free hole in the middle of primary
    wipe();
    for (int k = 0; k < 8; k++) if (k != 4) poke(2*k, 32'h8000_0000);
    run("R2 first free is slot 4", 0, 32'h0FC0_1000, 24'hFF_FFFF, 4'hF, 0);

    // R3: primary full -> secondary, flag set
    wipe();
    for (int k = 0; k < 8; k++) poke(2*k, 32'h8000_0001);
    poke(16, 32'h8000_0000);
    run("R3 secondary placement", 0, 32'hFFFF_F000, 24'h00_0001, 4'h3, 0);

    // R4: everything valid -> error, no write
    for (int k = 0; k < 16; k++) poke(2*k, 32'h8000_0000 | k);
    run("R4 both groups full", 0, 32'h5555_5000, 24'hAA_AAAA, 4'h1, 0);

    // R8: replace; slot 0 invalid but changed (valid ignored), slot 5 unchanged
    wipe();
    for (int k = 0; k < 16; k++) poke(2*k + 1, 32'h0000_0180);
    poke(0, 32'h0);
    poke(11, 32'h0000_0100);
    run("R8 replace primary victim", 1, 32'h7654_3000, 24'h13_5791, 4'h6, 0);

    // R8: primary all changed, secondary slot 2 unchanged
    poke(11, 32'h0000_0180);
    poke(16 + 5, 32'h0000_0000);
    run("R8 replace secondary victim", 1, 32'h2222_2000, 24'h24_6802, 4'h9, 0);

    // R9: all 16 changed -> overwrite secondary slot 7
    poke(16 + 5, 32'h0000_0080);
    run("R9 all changed fallback", 1, 32'h3333_3000, 24'h11_1111, 4'hC, 0);

    // R10: start while busy is ignored
    wipe();
    run("R10 start while busy", 0, 32'h4444_4000, 24'h22_2222, 4'h2, 1);

    repeat (3) @(negedge clk);
    chk(!busy && !done, "R10 idle at end", {busy, done}, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule